// File: doc/BRIEF.md
# Prescaled Dual-Source Time Base

This block keeps a free-running 24-bit time count for a timer subsystem. A programmable prescaler divides the system clock by an even ratio from 2 to 512. The count advances by one on each prescaler tick. A source select can instead make the count advance on tick pulses from another time base's prescaler. The count goes straight out on a port, so other timer modules can use it and the host can read it at any moment. The internal prescaler tick is also driven out for downstream use.

The ratio is coded as an 8-bit field N, and the division ratio is 2*(N+1). When the field changes, the prescaler phase restarts, so the new ratio applies from a clean phase. A low enable freezes the count and holds the prescaler at phase zero.

Top module: `tbase_prescaled`

## Requirements
- R1: While rst_n is low, count is 0 and tick_out is 0.
- R2: With en high and src_sel = 0, count rises by one every 2*(N+1) clock edges, where N = div_code (8 bits, 0..255, so the ratio runs from 2 to 512). After a phase restart, the first increment lands on exactly the 2*(N+1)-th enabled edge.
- R3: tick_out is high for exactly one cycle in each prescale period: in the cycle before the edge that would advance an internally clocked count. It is never high two cycles in a row.
- R4: With en high and src_sel = 1, count rises by one on each edge where ext_tick is high. Internal prescaler ticks do not move it.
- R5: count wraps from all ones (0xFFFFFF) to 0 on the next advance.
- R6: On the edge where a changed div_code is first seen, the phase is cleared and no internal tick is issued. The first increment then follows 2*(N+1)+1 edges after the change.
- R7: With en low, count holds (ext_tick included), tick_out stays 0 and the prescaler phase is cleared. After re-enabling, the first internal increment takes a full 2*(N+1) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counter and prescaler enable |
| src_sel | input | 1 | 0: internal prescaler, 1: external tick |
| div_code | input | 8 | Prescale code N, ratio 2*(N+1) |
| ext_tick | input | 1 | Tick pulse from the other time base's prescaler |
| count | output | 24 | Time base value, exported and readable by the host |
| tick_out | output | 1 | Internal prescaler tick |

## Verification
An input applied before an edge moves count on that same edge, so the new count appears one cycle later. tick_out is combinational from registered phase, so it is due in the cycle that the phase reaches 2N+1. The bench drives inputs on falling edges and samples on falling edges, and it counts exactly k rising edges for each stimulus. Each expected count is therefore floor(k / 2(N+1)) for the internal source, or k for the external source. The change and re-enable cases are checked one edge before and one edge after the due increment.

// File: rtl/tbase_prescaled.sv
module tbase_prescaled #(
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_code,
  input  logic             ext_tick,
  output logic [CNT_W-1:0] count,
  output logic             tick_out
);

  localparam int PH_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  ph;
  logic             chg;
  logic             adv;

  assign chg      = div_code != div_q;
  assign tick_out = en && !chg && (ph == {div_q, 1'b1});
  assign adv      = en && (src_sel ? ext_tick : tick_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ph    <= '0;
      count <= '0;
    end else begin
      div_q <= div_code;
      if (!en || chg || tick_out) ph <= '0;
      else                        ph <= ph + 1'b1;
      if (adv) count <= count + 1'b1;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= {div_q, 1'b1}); // R2

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out); // R3

  AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !src_sel && tick_out) |=> count == $past(count) + 1'b1); // R2

  AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && src_sel && ext_tick) |=> count == $past(count) + 1'b1); // R4

  AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && src_sel && !ext_tick) |=> $stable(count)); // R4

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count)); // R7

endmodule

// File: tb/tbase_prescaled_test.sv
`timescale 1ns/1ps
module tbase_prescaled_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        src_sel = 0;
  logic [7:0]  div_code = 0;
  logic        ext_tick = 0;
  logic [23:0] count;
  logic        tick_out;
  logic [3:0]  count_w;
  logic        tick_w;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tbase_prescaled uut (.clk, .rst_n, .en, .src_sel, .div_code, .ext_tick,
                       .count, .tick_out);
  tbase_prescaled #(.CNT_W(4)) uut_w (.clk, .rst_n, .en, .src_sel, .div_code,
                       .ext_tick, .count(count_w), .tick_out(tick_w));

  localparam int NV = 8;
  localparam int VN[NV]  = '{0, 1, 4, 255, 7, 0, 0, 2};
  localparam int VS[NV]  = '{0, 0, 0, 0,   0, 1, 1, 1};
  localparam int VE[NV]  = '{0, 0, 0, 0,   0, 1, 0, 1};
  localparam int VK[NV]  = '{10, 20, 35, 1030, 15, 7, 10, 40};
  localparam int VX[NV]  = '{5, 5, 3, 2, 0, 7, 0, 40};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(int n, bit s, bit e);
    @(negedge clk);
    rst_n = 0; en = 0; div_code = 8'(n); src_sel = s; ext_tick = e;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 tick_out in reset", int'(tick_out), 0);

    for (int i = 0; i < NV; i++) begin
      restart(VN[i], VS[i] != 0, VE[i] != 0);
      repeat (VK[i]) @(negedge clk);
      check(VS[i] != 0 ? "R4 external count" : "R2 internal count",
            int'(count), VX[i]);
    end

    // R3: tick_out due when phase reaches 2N+1
    restart(1, 0, 0);
    repeat (2) @(negedge clk);
    check("R3 tick before due", int'(tick_out), 0);
    @(negedge clk);
    check("R3 tick due", int'(tick_out), 1);
    @(negedge clk);
    check("R3 tick one cycle", int'(tick_out), 0);
    check("R2 count after first tick", int'(count), 1);

    // R7: disable holds count, ignores ext_tick, clears phase
    repeat (2) @(negedge clk);
    en = 0; src_sel = 1; ext_tick = 1;
    repeat (20) @(negedge clk);
    check("R7 count held", int'(count), 1);
    check("R7 tick_out low", int'(tick_out), 0);
    src_sel = 0; ext_tick = 0; en = 1;
    repeat (3) @(negedge clk);
    check("R7 no early tick after enable", int'(count), 1);
    @(negedge clk);
    check("R7 full period after enable", int'(count), 2);

    // R6: ratio change restarts the phase
    restart(3, 0, 0);
    repeat (5) @(negedge clk);
    div_code = 0;
    repeat (2) @(negedge clk);
    check("R6 no tick on change", int'(count), 0);
    check("R6 tick_out at new phase", int'(tick_out), 1);
    @(negedge clk);
    check("R6 first tick at new ratio", int'(count), 1);

    // R5: wrap on the narrow instance
    restart(0, 1, 1);
    repeat (15) @(negedge clk);
    check("R5 all ones", int'(count_w), 15);
    @(negedge clk);
    check("R5 wrap to zero", int'(count_w), 0);
    @(negedge clk);
    check("R5 after wrap", int'(count_w), 1);
    check("R4 wide count continues", int'(count), 17);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule